// File: doc/BRIEF.md
# Operand Source Selector with Port-Limited Register File

This block sits at the rename and operand-read stage of an out-of-order core that keeps speculative results in the reorder buffer. For each source of each micro-op in an issue group, it decides where the operand comes from. There are three places it can come from. A result being written back in this cycle is taken from the bypass network. A value whose producer is still in flight is read from the producer's reorder-buffer entry. A value that has already retired is read from the architectural register file.

The architectural register file has fewer read ports (`NUM_RD_PORTS`, default 2) than a full group can need. The block therefore counts the distinct retired registers the group reads and hands out ports in program order. Micro-ops that cannot be fully served are held, and `stall` is raised. Micro-ops whose sources live in the reorder buffer or on the bypass cost no port.

One consequence follows from this. Rewriting a retired register with a register-to-register move gives it a fresh reorder-buffer copy. Later readers then need no port.

An internal rename table records, for each logical register, either "retired" or "in reorder buffer, entry n". The table is updated by the micro-ops that proceed, and by retirement.

Top module: `opsrc_sel`

## Requirements
- R1: Each source gets a 2-bit select code: 2'b00 bypass, 2'b01 reorder buffer, 2'b10 register file, 2'b11 unused source (src_used low). `src_tag` carries the entry index for codes 00 and 01 and is zero otherwise. Source i belongs to micro-op i/SRCS_PER_UOP, and its fields sit at `src_sel[2i+:2]`, `src_reg[4i+:4]`, `src_tag[5i+:5]` and `src_port[i]` with default parameters.
- R2: A used source whose register is marked retired, and which has no older producer in the group, selects 2'b10.
- R3: A used source whose register maps to a reorder-buffer entry that is not on a valid writeback lane this cycle selects 2'b01 with that entry as tag.
- R4: A used source mapped to an entry that matches the tag of any valid writeback lane (`wb_tag[5w+:5]`) selects 2'b00 with that tag.
- R5: If an older valid micro-op in the same group writes the source's register, the source selects the reorder buffer (or bypass) with the youngest such older producer's entry, overriding the rename table.
- R6: Sources in the same group that read the same retired register share one read port.
- R7: Ports are granted oldest micro-op first (micro-op 0 is oldest). A valid micro-op proceeds (`uop_go`) only if every older valid micro-op proceeds and the distinct register-file reads through its own sources number at most `NUM_RD_PORTS`. `stall` is high exactly when some valid micro-op is held.
- R8: Port p reads the p-th distinct retired register in source order, counting only proceeding micro-ops. `rf_rd_en[p]` is set and `rf_rd_addr[4p+:4]` holds that register. `src_port` gives each proceeding register-file source its port and is zero elsewhere. Unused ports have enable and address zero.
- R9: A proceeding micro-op with `dst_we` maps its destination register to its `dst_rob` entry from the next cycle. A held micro-op changes no mapping. Among same-cycle writers of one register, the youngest wins.
- R10: A retirement whose entry matches the current mapping of `ret_reg` returns that register to the register file. A retirement of a stale entry has no effect. A same-cycle rename write to that register takes precedence over the retirement.
- R11: After a move rewrites a retired register, later readers of that register take it from the reorder buffer and use no port, so a group that would otherwise stall proceeds in full.
- R12: After reset every logical register is marked retired and no micro-op proceeds while none is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | GROUP_W | Micro-op present in the group slot |
| src_used | input | GROUP_W*SRCS_PER_UOP | Source reads a register |
| src_reg | input | GROUP_W*SRCS_PER_UOP*AW | Logical source registers |
| dst_we | input | GROUP_W | Micro-op writes a destination |
| dst_reg | input | GROUP_W*AW | Logical destination register |
| dst_rob | input | GROUP_W*RW | Reorder-buffer entry given to the micro-op |
| wb_valid | input | NUM_WB | Writeback lane active |
| wb_tag | input | NUM_WB*RW | Entry completing on each lane |
| ret_valid | input | 1 | A micro-op retires |
| ret_reg | input | AW | Destination register of the retiring micro-op |
| ret_rob | input | RW | Entry of the retiring micro-op |
| src_sel | output | GROUP_W*SRCS_PER_UOP*2 | Select code per source |
| src_tag | output | GROUP_W*SRCS_PER_UOP*RW | Entry index for bypass/ROB sources |
| src_port | output | GROUP_W*SRCS_PER_UOP*PW | Read port for register-file sources |
| rf_rd_en | output | NUM_RD_PORTS | Register-file port enables |
| rf_rd_addr | output | NUM_RD_PORTS*AW | Register-file port addresses |
| uop_go | output | GROUP_W | Micro-op proceeds this cycle |
| stall | output | 1 | Some valid micro-op is held |

## Verification
Two functions can fall in the same cycle: bypass selection for one source, and a port-limit stall caused by retired sources elsewhere in the group. The bench provokes this by driving a writeback tag that matches a mapped register, in a group whose other sources need three register-file reads. It expects code 00 on the bypassed source, a grant only to the oldest micro-op, and only one port enabled. A second overlap is a rename write and a retirement of the same register in one cycle. It is judged by the select code that the next group's reader receives.

// File: rtl/opsrc_pkg.sv
package opsrc_pkg;

  typedef enum logic [1:0] {
    SEL_BYP  = 2'b00,
    SEL_ROB  = 2'b01,
    SEL_ARF  = 2'b10,
    SEL_NONE = 2'b11
  } src_sel_e;

  // micro-op slot that owns flat source index s
  function automatic int unsigned owner_uop(int unsigned s, int unsigned per_uop);
    return s / per_uop;
  endfunction

  // true when a cumulative read demand fits the available ports
  function automatic logic ports_fit(int unsigned demand, int unsigned avail);
    return demand <= avail;
  endfunction

  // select code from the resolved location of one source
  function automatic src_sel_e pick_sel(logic used, logic in_flight, logic on_wb);
    if (!used)     return SEL_NONE;
    if (!in_flight) return SEL_ARF;
    return on_wb ? SEL_BYP : SEL_ROB;
  endfunction

endpackage

// File: rtl/opsrc_rename_tbl.sv
module opsrc_rename_tbl #(
  parameter int NUM_ARCH = 16,
  parameter int GROUP_W  = 3,
  parameter int AW       = 4,
  parameter int RW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GROUP_W-1:0] wr_en,
  input  logic [AW-1:0]     wr_reg [GROUP_W],
  input  logic [RW-1:0]     wr_rob [GROUP_W],
  input  logic              ret_valid,
  input  logic [AW-1:0]     ret_reg,
  input  logic [RW-1:0]     ret_rob,
  output logic              map_in_rob [NUM_ARCH],
  output logic [RW-1:0]     map_rob [NUM_ARCH],
  output logic              ret_clear_evt
);

  logic              in_rob_q [NUM_ARCH];
  logic [RW-1:0]     rob_q    [NUM_ARCH];
  logic              ret_overwrite;

  always_comb begin
    ret_overwrite = 1'b0;
    for (int k = 0; k < GROUP_W; k++)
      if (wr_en[k] && wr_reg[k] == ret_reg) ret_overwrite = 1'b1;
    ret_clear_evt = ret_valid && in_rob_q[ret_reg] && (rob_q[ret_reg] == ret_rob)
                    && !ret_overwrite;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ARCH; r++) begin
        in_rob_q[r] <= 1'b0;
        rob_q[r]    <= '0;
      end
    end else begin
      if (ret_clear_evt) in_rob_q[ret_reg] <= 1'b0;
      for (int k = 0; k < GROUP_W; k++) begin
        if (wr_en[k]) begin
          in_rob_q[wr_reg[k]] <= 1'b1;
          rob_q[wr_reg[k]]    <= wr_rob[k];
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_ARCH; r++) begin
      map_in_rob[r] = in_rob_q[r];
      map_rob[r]    = rob_q[r];
    end
  end

endmodule

// File: rtl/opsrc_classify.sv
module opsrc_classify
  import opsrc_pkg::*;
#(
  parameter int NUM_ARCH     = 16,
  parameter int GROUP_W      = 3,
  parameter int SRCS_PER_UOP = 2,
  parameter int NUM_WB       = 2,
  parameter int AW           = 4,
  parameter int RW           = 5,
  localparam int NSRC        = GROUP_W * SRCS_PER_UOP
) (
  input  logic [GROUP_W-1:0] uop_valid,
  input  logic [NSRC-1:0]    src_used,
  input  logic [AW-1:0]      src_reg [NSRC],
  input  logic [GROUP_W-1:0] dst_we,
  input  logic [AW-1:0]      dst_reg [GROUP_W],
  input  logic [RW-1:0]      dst_rob [GROUP_W],
  input  logic               map_in_rob [NUM_ARCH],
  input  logic [RW-1:0]      map_rob [NUM_ARCH],
  input  logic [NUM_WB-1:0]  wb_valid,
  input  logic [RW-1:0]      wb_tag [NUM_WB],
  output src_sel_e           sel [NSRC],
  output logic [RW-1:0]      tag [NSRC],
  output logic [NSRC-1:0]    need_arf
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int K = owner_uop(i, SRCS_PER_UOP);
    logic          in_flight;
    logic          on_wb;
    logic [RW-1:0] ent;

    always_comb begin
      in_flight = map_in_rob[src_reg[i]];
      ent       = map_rob[src_reg[i]];
      // older producers in the same group override the table, youngest last
      for (int j = 0; j < K; j++) begin
        if (uop_valid[j] && dst_we[j] && dst_reg[j] == src_reg[i]) begin
          in_flight = 1'b1;
          ent       = dst_rob[j];
        end
      end
      on_wb = 1'b0;
      for (int w = 0; w < NUM_WB; w++)
        if (wb_valid[w] && wb_tag[w] == ent) on_wb = 1'b1;
    end

    assign sel[i]      = pick_sel(src_used[i], in_flight, on_wb);
    assign tag[i]      = (src_used[i] && in_flight) ? ent : '0;
    assign need_arf[i] = src_used[i] && !in_flight && uop_valid[K];
  end

endmodule

// File: rtl/opsrc_port_alloc.sv
module opsrc_port_alloc
  import opsrc_pkg::*;
#(
  parameter int GROUP_W      = 3,
  parameter int SRCS_PER_UOP = 2,
  parameter int NUM_RD_PORTS = 2,
  parameter int AW           = 4,
  localparam int NSRC        = GROUP_W * SRCS_PER_UOP,
  localparam int PW          = (NUM_RD_PORTS > 1) ? $clog2(NUM_RD_PORTS) : 1,
  localparam int CW          = $clog2(NSRC + 1)
) (
  input  logic [GROUP_W-1:0]      uop_valid,
  input  logic [NSRC-1:0]         need_arf,
  input  logic [AW-1:0]           src_reg [NSRC],
  output logic [GROUP_W-1:0]      uop_go,
  output logic [PW-1:0]           src_port [NSRC],
  output logic [NUM_RD_PORTS-1:0] rd_en,
  output logic [AW-1:0]           rd_addr [NUM_RD_PORTS],
  output logic                    stall
);

  logic [NSRC-1:0] first_use;
  logic [CW-1:0]   rank [NSRC];
  logic [CW-1:0]   demand_through [GROUP_W];
  logic [CW-1:0]   cnt;
  logic            blocked;

  // distinct register-file reads in source order, with a rank per source
  always_comb begin
    cnt = '0;
    for (int i = 0; i < NSRC; i++) begin
      first_use[i] = need_arf[i];
      rank[i]      = cnt;
      for (int j = 0; j < i; j++) begin
        if (need_arf[i] && need_arf[j] && src_reg[j] == src_reg[i] && first_use[i]) begin
          first_use[i] = 1'b0;
          rank[i]      = rank[j];
        end
      end
      if (first_use[i]) cnt = cnt + CW'(1);
      if ((i % SRCS_PER_UOP) == SRCS_PER_UOP - 1)
        demand_through[i / SRCS_PER_UOP] = cnt;
    end
  end

  // in-order grant: a held micro-op blocks every younger one
  always_comb begin
    blocked = 1'b0;
    for (int k = 0; k < GROUP_W; k++) begin
      uop_go[k] = uop_valid[k] && !blocked && ports_fit(int'(demand_through[k]), NUM_RD_PORTS);
      if (uop_valid[k] && !uop_go[k]) blocked = 1'b1;
    end
    stall = blocked;
  end

  always_comb begin
    rd_en = '0;
    for (int p = 0; p < NUM_RD_PORTS; p++) rd_addr[p] = '0;
    for (int i = 0; i < NSRC; i++) begin
      src_port[i] = '0;
      for (int p = 0; p < NUM_RD_PORTS; p++) begin
        if (need_arf[i] && uop_go[i / SRCS_PER_UOP] && rank[i] == CW'(p)) begin
          src_port[i] = PW'(p);
          if (first_use[i]) begin
            rd_en[p]   = 1'b1;
            rd_addr[p] = src_reg[i];
          end
        end
      end
    end
  end

endmodule

// File: rtl/opsrc_sel.sv
module opsrc_sel
  import opsrc_pkg::*;
#(
  parameter int NUM_ARCH     = 16,
  parameter int ROB_DEPTH    = 32,
  parameter int GROUP_W      = 3,
  parameter int SRCS_PER_UOP = 2,
  parameter int NUM_RD_PORTS = 2,
  parameter int NUM_WB       = 2,
  localparam int AW          = $clog2(NUM_ARCH),
  localparam int RW          = $clog2(ROB_DEPTH),
  localparam int NSRC        = GROUP_W * SRCS_PER_UOP,
  localparam int PW          = (NUM_RD_PORTS > 1) ? $clog2(NUM_RD_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [GROUP_W-1:0]         uop_valid,
  input  logic [NSRC-1:0]            src_used,
  input  logic [NSRC*AW-1:0]         src_reg,
  input  logic [GROUP_W-1:0]         dst_we,
  input  logic [GROUP_W*AW-1:0]      dst_reg,
  input  logic [GROUP_W*RW-1:0]      dst_rob,
  input  logic [NUM_WB-1:0]          wb_valid,
  input  logic [NUM_WB*RW-1:0]       wb_tag,
  input  logic                       ret_valid,
  input  logic [AW-1:0]              ret_reg,
  input  logic [RW-1:0]              ret_rob,
  output logic [NSRC*2-1:0]          src_sel,
  output logic [NSRC*RW-1:0]         src_tag,
  output logic [NSRC*PW-1:0]         src_port,
  output logic [NUM_RD_PORTS-1:0]    rf_rd_en,
  output logic [NUM_RD_PORTS*AW-1:0] rf_rd_addr,
  output logic [GROUP_W-1:0]         uop_go,
  output logic                       stall
);

  logic [AW-1:0] s_reg   [NSRC];
  logic [AW-1:0] d_reg   [GROUP_W];
  logic [RW-1:0] d_rob   [GROUP_W];
  logic [RW-1:0] w_tag   [NUM_WB];
  logic          m_in    [NUM_ARCH];
  logic [RW-1:0] m_rob   [NUM_ARCH];
  src_sel_e      c_sel   [NSRC];
  logic [RW-1:0] c_tag   [NSRC];
  logic [PW-1:0] c_port  [NSRC];
  logic [AW-1:0] c_addr  [NUM_RD_PORTS];
  logic [NSRC-1:0] need_arf;

  // named internal events for the checker
  logic [NUM_ARCH-1:0] tbl_in_rob;
  logic                ret_clear_evt;

  for (genvar i = 0; i < NSRC; i++) begin : g_s
    assign s_reg[i]               = src_reg[i*AW +: AW];
    assign src_sel[i*2 +: 2]      = c_sel[i];
    assign src_tag[i*RW +: RW]    = c_tag[i];
    assign src_port[i*PW +: PW]   = c_port[i];
  end
  for (genvar k = 0; k < GROUP_W; k++) begin : g_u
    assign d_reg[k] = dst_reg[k*AW +: AW];
    assign d_rob[k] = dst_rob[k*RW +: RW];
  end
  for (genvar w = 0; w < NUM_WB; w++) begin : g_w
    assign w_tag[w] = wb_tag[w*RW +: RW];
  end
  for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_p
    assign rf_rd_addr[p*AW +: AW] = c_addr[p];
  end
  for (genvar r = 0; r < NUM_ARCH; r++) begin : g_r
    assign tbl_in_rob[r] = m_in[r];
  end

  opsrc_rename_tbl #(
    .NUM_ARCH(NUM_ARCH), .GROUP_W(GROUP_W), .AW(AW), .RW(RW)
  ) tbl_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dst_we & uop_go), .wr_reg(d_reg), .wr_rob(d_rob),
    .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_rob(ret_rob),
    .map_in_rob(m_in), .map_rob(m_rob), .ret_clear_evt(ret_clear_evt)
  );

  opsrc_classify #(
    .NUM_ARCH(NUM_ARCH), .GROUP_W(GROUP_W), .SRCS_PER_UOP(SRCS_PER_UOP),
    .NUM_WB(NUM_WB), .AW(AW), .RW(RW)
  ) cls_i (
    .uop_valid(uop_valid), .src_used(src_used), .src_reg(s_reg),
    .dst_we(dst_we), .dst_reg(d_reg), .dst_rob(d_rob),
    .map_in_rob(m_in), .map_rob(m_rob),
    .wb_valid(wb_valid), .wb_tag(w_tag),
    .sel(c_sel), .tag(c_tag), .need_arf(need_arf)
  );

  opsrc_port_alloc #(
    .GROUP_W(GROUP_W), .SRCS_PER_UOP(SRCS_PER_UOP),
    .NUM_RD_PORTS(NUM_RD_PORTS), .AW(AW)
  ) alloc_i (
    .uop_valid(uop_valid), .need_arf(need_arf), .src_reg(s_reg),
    .uop_go(uop_go), .src_port(c_port),
    .rd_en(rf_rd_en), .rd_addr(c_addr), .stall(stall)
  );

endmodule

// File: rtl/opsrc_sel_sva.sv
module opsrc_sel_sva #(
  parameter int NUM_ARCH     = 16,
  parameter int GROUP_W      = 3,
  parameter int SRCS_PER_UOP = 2,
  parameter int NUM_RD_PORTS = 2,
  parameter int NUM_WB       = 2,
  parameter int AW           = 4,
  parameter int RW           = 5,
  parameter int PW           = 1,
  localparam int NSRC        = GROUP_W * SRCS_PER_UOP
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [GROUP_W-1:0]         uop_valid,
  input logic [NSRC-1:0]            src_used,
  input logic [NSRC*AW-1:0]         src_reg,
  input logic [NSRC*2-1:0]          src_sel,
  input logic [NSRC*RW-1:0]         src_tag,
  input logic [NSRC*PW-1:0]         src_port,
  input logic [NUM_WB-1:0]          wb_valid,
  input logic [NUM_WB*RW-1:0]       wb_tag,
  input logic [NUM_RD_PORTS-1:0]    rf_rd_en,
  input logic [NUM_RD_PORTS*AW-1:0] rf_rd_addr,
  input logic [GROUP_W-1:0]         uop_go,
  input logic                       stall,
  input logic [AW-1:0]              ret_reg,
  input logic                       ret_clear_evt,
  input logic [NUM_ARCH-1:0]        tbl_in_rob
);

  // R7: only valid micro-ops proceed
  a_r7_go_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_go & ~uop_valid) == '0);

  // R7: no stall means every valid micro-op proceeds
  a_r7_no_stall_all_go: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> uop_go == uop_valid);

  // R10: a matching retirement leaves the register marked retired next cycle
  a_r10_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
    ret_clear_evt |=> !tbl_in_rob[$past(ret_reg)]);

  for (genvar k = 1; k < GROUP_W; k++) begin : g_ord
    // R7: a younger micro-op never passes a held older one
    a_r7_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      uop_go[k] |-> (uop_valid[k-1:0] & ~uop_go[k-1:0]) == '0);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int K = i / SRCS_PER_UOP;
    logic [PW-1:0] prt;
    logic [AW-1:0] rg;
    logic          wb_hit;
    assign prt = src_port[i*PW +: PW];
    assign rg  = src_reg[i*AW +: AW];
    always_comb begin
      wb_hit = 1'b0;
      for (int w = 0; w < NUM_WB; w++)
        if (wb_valid[w] && wb_tag[w*RW +: RW] == src_tag[i*RW +: RW]) wb_hit = 1'b1;
    end

    // R1: unused sources carry the no-source code
    a_r1_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
      !src_used[i] |-> src_sel[i*2 +: 2] == 2'b11);

    // R4: a bypass code always names a live writeback tag
    a_r4_bypass_live: assert property (@(posedge clk) disable iff (!rst_n)
      src_sel[i*2 +: 2] == 2'b00 |-> wb_hit);

    // R8: a served register-file source finds its register on its port
    a_r8_port_carries_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_go[K] && src_sel[i*2 +: 2] == 2'b10)
        |-> (rf_rd_en[prt] && rf_rd_addr[prt*AW +: AW] == rg));
  end

endmodule

bind opsrc_sel opsrc_sel_sva #(
  .NUM_ARCH(NUM_ARCH), .GROUP_W(GROUP_W), .SRCS_PER_UOP(SRCS_PER_UOP),
  .NUM_RD_PORTS(NUM_RD_PORTS), .NUM_WB(NUM_WB), .AW(AW), .RW(RW), .PW(PW)
) sva_i (
  .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .src_used(src_used),
  .src_reg(src_reg), .src_sel(src_sel), .src_tag(src_tag), .src_port(src_port),
  .wb_valid(wb_valid), .wb_tag(wb_tag), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr),
  .uop_go(uop_go), .stall(stall), .ret_reg(ret_reg),
  .ret_clear_evt(ret_clear_evt), .tbl_in_rob(tbl_in_rob)
);

// File: tb/opsrc_sel_tb.sv
module opsrc_sel_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [2:0]  uop_valid, dst_we, uop_go;
  logic [5:0]  src_used, src_port;
  logic [23:0] src_reg;
  logic [11:0] dst_reg, src_sel;
  logic [14:0] dst_rob;
  logic [1:0]  wb_valid, rf_rd_en;
  logic [9:0]  wb_tag;
  logic        ret_valid, stall;
  logic [3:0]  ret_reg;
  logic [4:0]  ret_rob;
  logic [29:0] src_tag;
  logic [7:0]  rf_rd_addr;

  opsrc_sel dut_i (
    .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid), .src_used(src_used),
    .src_reg(src_reg), .dst_we(dst_we), .dst_reg(dst_reg), .dst_rob(dst_rob),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .ret_valid(ret_valid),
    .ret_reg(ret_reg), .ret_rob(ret_rob), .src_sel(src_sel), .src_tag(src_tag),
    .src_port(src_port), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr),
    .uop_go(uop_go), .stall(stall)
  );

  typedef struct {
    string       lbl;
    logic [11:0] sel;
    logic [29:0] tag;
    logic [5:0]  port;
    logic [2:0]  go;
    logic        stl;
    logic [1:0]  rden;
    logic [7:0]  addr;
  } exp_t;

  exp_t e;
  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // staged stimulus, copied to the design at a falling edge
  logic [2:0]  n_valid, n_dwe;
  logic [5:0]  n_used;
  logic [23:0] n_reg;
  logic [11:0] n_dreg;
  logic [14:0] n_drob;
  logic [1:0]  n_wbv;
  logic [9:0]  n_wbt;
  logic        n_retv;
  logic [3:0]  n_retr;
  logic [4:0]  n_reto;

  task automatic clr();
    n_valid = '0; n_dwe = '0; n_used = '0; n_reg = '0; n_dreg = '0; n_drob = '0;
    n_wbv = '0; n_wbt = '0; n_retv = 1'b0; n_retr = '0; n_reto = '0;
    e.sel = '1; e.tag = '0; e.port = '0; e.go = '0; e.stl = 1'b0;
    e.rden = '0; e.addr = '0;
  endtask

  task automatic src(int i, int r);
    n_used[i] = 1'b1; n_reg[i*4 +: 4] = 4'(r);
  endtask

  task automatic dst(int k, int r, int rob);
    n_dwe[k] = 1'b1; n_dreg[k*4 +: 4] = 4'(r); n_drob[k*5 +: 5] = 5'(rob);
  endtask

  task automatic es(int i, logic [1:0] s, int tg, int pt);
    e.sel[i*2 +: 2] = s; e.tag[i*5 +: 5] = 5'(tg); e.port[i] = pt[0];
  endtask

  task automatic ep(int p, int r);
    e.rden[p] = 1'b1; e.addr[p*4 +: 4] = 4'(r);
  endtask

  // driver: apply staged inputs at a falling edge and queue the expectation
  task automatic step(string lbl);
    @(negedge clk);
    uop_valid = n_valid; dst_we = n_dwe; src_used = n_used; src_reg = n_reg;
    dst_reg = n_dreg; dst_rob = n_drob; wb_valid = n_wbv; wb_tag = n_wbt;
    ret_valid = n_retv; ret_reg = n_retr; ret_rob = n_reto;
    e.lbl = lbl;
    q.push_back(e);
  endtask

  task automatic cmp(string lbl, string f, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", lbl, f, act, exp);
    end
  endtask

  // monitor: sample mid low phase, compare against the queue head
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        cmp(x.lbl, "src_sel", 32'(src_sel), 32'(x.sel));
        cmp(x.lbl, "src_tag", 32'(src_tag), 32'(x.tag));
        cmp(x.lbl, "src_port", 32'(src_port), 32'(x.port));
        cmp(x.lbl, "uop_go", 32'(uop_go), 32'(x.go));
        cmp(x.lbl, "stall", 32'(stall), 32'(x.stl));
        cmp(x.lbl, "rf_rd_en", 32'(rf_rd_en), 32'(x.rden));
        cmp(x.lbl, "rf_rd_addr", 32'(rf_rd_addr), 32'(x.addr));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    clr();
    uop_valid = '0; dst_we = '0; src_used = '0; src_reg = '0; dst_reg = '0;
    dst_rob = '0; wb_valid = '0; wb_tag = '0; ret_valid = 1'b0; ret_reg = '0; ret_rob = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    clr(); step("R12 idle after reset");

    // R2 R7 R8: three distinct retired reads, two ports
    clr(); n_valid = 3'b011; src(0, 1); src(1, 2); src(2, 3);
    es(0, 2'b10, 0, 0); es(1, 2'b10, 0, 1); es(2, 2'b10, 0, 0);
    e.go = 3'b001; e.stl = 1'b1; ep(0, 1); ep(1, 2);
    step("R7 port limit stall");

    // R6: shared reads
    clr(); n_valid = 3'b111; src(0, 5); src(1, 5); src(2, 5); src(3, 6); src(4, 6);
    es(0, 2'b10, 0, 0); es(1, 2'b10, 0, 0); es(2, 2'b10, 0, 0);
    es(3, 2'b10, 0, 1); es(4, 2'b10, 0, 1);
    e.go = 3'b111; ep(0, 5); ep(1, 6);
    step("R6 shared port");

    // R7: younger fitting uop still blocked
    clr(); n_valid = 3'b111; src(0, 1); src(2, 2); src(3, 3); src(4, 1);
    es(0, 2'b10, 0, 0); es(2, 2'b10, 0, 0); es(3, 2'b10, 0, 0); es(4, 2'b10, 0, 0);
    e.go = 3'b001; e.stl = 1'b1; ep(0, 1);
    step("R7 in-order block");

    // R5 R9: in-group producer, then mapping persists
    clr(); n_valid = 3'b011; dst(0, 4, 7); src(2, 4);
    es(2, 2'b01, 7, 0); e.go = 3'b011;
    step("R5 in-group forward");

    // R3: ROB source uses no port
    clr(); n_valid = 3'b111; src(0, 4); src(2, 8); src(3, 9); src(4, 10);
    es(0, 2'b01, 7, 0); es(2, 2'b10, 0, 0); es(3, 2'b10, 0, 1); es(4, 2'b10, 0, 0);
    e.go = 3'b011; e.stl = 1'b1; ep(0, 8); ep(1, 9);
    step("R3 rob no port");

    // R4 with R7: bypass in a stalling group
    clr(); n_valid = 3'b011; n_wbv = 2'b01; n_wbt[4:0] = 5'd7;
    src(0, 4); src(1, 1); src(2, 2); src(3, 3);
    es(0, 2'b00, 7, 0); es(1, 2'b10, 0, 0); es(2, 2'b10, 0, 0); es(3, 2'b10, 0, 0);
    e.go = 3'b001; e.stl = 1'b1; ep(0, 1);
    step("R4 bypass during stall");

    // R4: second lane
    clr(); n_valid = 3'b001; n_wbv = 2'b10; n_wbt = {5'd7, 5'd3}; src(0, 4);
    es(0, 2'b00, 7, 0); e.go = 3'b001;
    step("R4 lane1 bypass");

    // R10: retire returns r4
    clr(); n_retv = 1'b1; n_retr = 4'd4; n_reto = 5'd7; step("R10 retire idle");
    clr(); n_valid = 3'b001; src(0, 4); es(0, 2'b10, 0, 0); e.go = 3'b001; ep(0, 4);
    step("R10 retired read");

    // R10: stale retirement ignored
    clr(); n_valid = 3'b001; dst(0, 5, 9); e.go = 3'b001; step("R9 map r5 9");
    clr(); n_valid = 3'b001; dst(0, 5, 12); e.go = 3'b001; step("R9 map r5 12");
    clr(); n_retv = 1'b1; n_retr = 4'd5; n_reto = 5'd9; step("R10 stale retire");
    clr(); n_valid = 3'b001; src(0, 5); es(0, 2'b01, 12, 0); e.go = 3'b001;
    step("R10 stale no effect");

    // R11: move refresh removes a stall
    clr(); n_valid = 3'b001; src(0, 6); dst(0, 6, 3);
    es(0, 2'b10, 0, 0); e.go = 3'b001; ep(0, 6);
    step("R11 move");
    clr(); n_valid = 3'b111; src(0, 6); src(1, 1); src(2, 6); src(3, 2); src(4, 6);
    es(0, 2'b01, 3, 0); es(1, 2'b10, 0, 0); es(2, 2'b01, 3, 0);
    es(3, 2'b10, 0, 1); es(4, 2'b01, 3, 0);
    e.go = 3'b111; ep(0, 1); ep(1, 2);
    step("R11 refreshed group");

    // R10: rename write beats same-cycle retirement
    clr(); n_valid = 3'b001; dst(0, 7, 4); e.go = 3'b001; step("R9 map r7");
    clr(); n_valid = 3'b001; dst(0, 7, 20); n_retv = 1'b1; n_retr = 4'd7; n_reto = 5'd4;
    e.go = 3'b001; step("R10 write and retire");
    clr(); n_valid = 3'b001; src(0, 7); es(0, 2'b01, 20, 0); e.go = 3'b001;
    step("R10 write wins");

    // R9: held uop writes no mapping
    clr(); n_valid = 3'b011; src(0, 1); src(1, 2); src(2, 3); dst(1, 11, 15);
    es(0, 2'b10, 0, 0); es(1, 2'b10, 0, 1); es(2, 2'b10, 0, 0);
    e.go = 3'b001; e.stl = 1'b1; ep(0, 1); ep(1, 2);
    step("R9 held dest");
    clr(); n_valid = 3'b001; src(0, 11); es(0, 2'b10, 0, 0); e.go = 3'b001; ep(0, 11);
    step("R9 held no map");

    // R5: youngest older producer wins
    clr(); n_valid = 3'b111; dst(0, 12, 1); dst(1, 12, 2); src(4, 12);
    es(4, 2'b01, 2, 0); e.go = 3'b111;
    step("R5 youngest producer");

    // R9: youngest same-cycle writer sets the map
    clr(); n_valid = 3'b001; src(0, 12); es(0, 2'b01, 2, 0); e.go = 3'b001;
    step("R9 youngest writer");

    clr(); step("R1 idle tail");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule